// File: doc/BRIEF.md
# Port Link-Up and Traffic Activity Indicator

This block produces the two per-port status lines that an external I/O expander turns into LEDs or debug signals. It takes the link training state code and raises an active-low link-up line while the data link layer is usable. It also watches the transmit and receive TLP strobes and raises an active-low activity line for each qualifying packet. That activity indication is stretched so it stays visible across several expander refreshes.

The block only observes its inputs. The TLP strobes are single-cycle event flags taken from the datapath, and they carry no ready signal, so the block never applies back-pressure to the packet stream. A millisecond tick from a shared timebase drives the stretch counter. The hold time equals the expander refresh period multiplied by the number of refresh periods the pulse must cover.

Top module: `link_act_status`

## Requirements
- R1: With LTSSM codes L0=3, RECOVERY=4, L0S=5 or L1=6 on `ltssm_state` at a clock edge, `link_up_n` is 0 after that edge.
- R2: Every other `ltssm_state` code (DETECT=0, POLLING=1, CONFIG=2, L2=7, DISABLED=8, LOOPBACK=9, HOT_RESET=10, and the unused codes 11 to 15) drives `link_up_n` to 1 after that edge.
- R3: A TX or RX TLP strobe whose vendor-message flag is 0 drives `active_n` to 0 after the edge that samples it.
- R4: A strobe whose vendor-message flag is 1 has no effect: `active_n` does not go low, and a running hold is not restarted.
- R5: TX and RX strobes in the same cycle are combined with a logical OR. One qualifying strobe is enough, even if the other is a vendor message.
- R6: After the last qualifying strobe, `active_n` stays 0 until HOLD_MS millisecond ticks have been sampled. It returns to 1 at the edge that samples the HOLD_MS-th tick.
- R7: A qualifying strobe during a hold reloads the full HOLD_MS count. This includes a strobe in the same cycle as a tick, where the reload wins.
- R8: `active_n` never rises in a cycle without a tick. Ticks while idle have no effect.
- R9: While `rst_n` is 0, both outputs are 1 and the hold count is cleared. A hold in progress is cancelled by reset.
- R10: HOLD_MS equals EXP_PERIOD_MS times HOLD_PERIODS. With the defaults of 40 and 5, it is 200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ltssm_state | input | STATE_W (4) | Current link training state code |
| tx_tlp_stb | input | 1 | One-cycle flag: a TLP was transmitted |
| tx_tlp_vdm | input | 1 | The transmitted TLP is a vendor-defined message |
| rx_tlp_stb | input | 1 | One-cycle flag: a TLP was received |
| rx_tlp_vdm | input | 1 | The received TLP is a vendor-defined message |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| link_up_n | output | 1 | Active-low link-up status |
| active_n | output | 1 | Active-low stretched traffic activity |

## Verification
The link decode is swept through all sixteen state codes, including the unused ones. This separates an exact-match decode from one that only tests a range or a bit. Activity is tried with:
- lone TX and lone RX strobes;
- vendor messages alone and paired with a qualifying strobe;
- both directions qualifying at once.

Together these show whether each direction and the vendor filter work independently. Hold timing is checked one tick before and at the expiry edge. Restarts are checked mid-hold and coincident with a tick, which exposes off-by-one errors and a tick-over-reload priority mistake. Idle ticks and a reset during a hold are also covered.

// File: rtl/link_act_pkg.sv
package link_act_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    LT_DETECT    = 4'd0,
    LT_POLLING   = 4'd1,
    LT_CONFIG    = 4'd2,
    LT_L0        = 4'd3,
    LT_RECOVERY  = 4'd4,
    LT_L0S       = 4'd5,
    LT_L1        = 4'd6,
    LT_L2        = 4'd7,
    LT_DISABLED  = 4'd8,
    LT_LOOPBACK  = 4'd9,
    LT_HOT_RESET = 4'd10
  } ltssm_e;

  function automatic logic dll_usable(input logic [STATE_W-1:0] code);
    case (code)
      LT_L0, LT_RECOVERY, LT_L0S, LT_L1: dll_usable = 1'b1;
      default:                           dll_usable = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/link_state_decode.sv
module link_state_decode
  import link_act_pkg::*;
#(
  parameter int SW = STATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] state,
  output logic          up_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_n <= 1'b1;
    else        up_n <= ~dll_usable(state);
  end
endmodule

// File: rtl/tlp_activity_qual.sv
module tlp_activity_qual #(
  parameter int N_DIR = 2
) (
  input  logic [N_DIR-1:0] stb,
  input  logic [N_DIR-1:0] vdm,
  output logic             hit
);
  logic [N_DIR-1:0] qual;
  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    assign qual[d] = stb[d] & ~vdm[d];
  end
  assign hit = |qual;
endmodule

// File: rtl/act_hold_timer.sv
module act_hold_timer #(
  parameter int HOLD = 200,
  localparam int CW = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic tick,
  output logic busy
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remain <= '0;
    else if (hit)                  remain <= CW'(HOLD);
    else if (tick && remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/link_act_status.sv
module link_act_status
  import link_act_pkg::*;
#(
  parameter int EXP_PERIOD_MS = 40,
  parameter int HOLD_PERIODS  = 5,
  localparam int HOLD_MS = EXP_PERIOD_MS * HOLD_PERIODS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic               tx_tlp_stb,
  input  logic               tx_tlp_vdm,
  input  logic               rx_tlp_stb,
  input  logic               rx_tlp_vdm,
  input  logic               ms_tick,
  output logic               link_up_n,
  output logic               active_n
);
  logic tlp_hit;
  logic hold_busy;

  link_state_decode #(.SW(STATE_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .state (ltssm_state),
    .up_n  (link_up_n)
  );

  tlp_activity_qual #(.N_DIR(2)) u_qual (
    .stb ({rx_tlp_stb, tx_tlp_stb}),
    .vdm ({rx_tlp_vdm, tx_tlp_vdm}),
    .hit (tlp_hit)
  );

  act_hold_timer #(.HOLD(HOLD_MS)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (tlp_hit),
    .tick  (ms_tick),
    .busy  (hold_busy)
  );

  assign active_n = ~hold_busy;
endmodule

// File: rtl/link_act_status_chk.sv
module link_act_status_chk
  import link_act_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] ltssm_state,
  input logic               tx_tlp_stb,
  input logic               tx_tlp_vdm,
  input logic               rx_tlp_stb,
  input logic               rx_tlp_vdm,
  input logic               ms_tick,
  input logic               link_up_n,
  input logic               active_n
);
  logic q_any;
  assign q_any = (tx_tlp_stb & ~tx_tlp_vdm) | (rx_tlp_stb & ~rx_tlp_vdm);

  p_link_l0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ltssm_state == LT_L0) |=> !link_up_n);
  p_link_down_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ltssm_state == LT_DETECT) |=> link_up_n);
  p_tx_sets_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tlp_stb && !tx_tlp_vdm) |=> !active_n);
  p_only_qual_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_n && !q_any) |=> active_n);
  p_rx_sets_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tlp_stb && !rx_tlp_vdm) |=> !active_n);
  p_no_release_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_n && !ms_tick) |=> !active_n);
  p_reload_beats_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_any && ms_tick) |=> !active_n);
endmodule

bind link_act_status link_act_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ltssm_state (ltssm_state),
  .tx_tlp_stb  (tx_tlp_stb),
  .tx_tlp_vdm  (tx_tlp_vdm),
  .rx_tlp_stb  (rx_tlp_stb),
  .rx_tlp_vdm  (rx_tlp_vdm),
  .ms_tick     (ms_tick),
  .link_up_n   (link_up_n),
  .active_n    (active_n)
);

// File: tb/tb_link_act_status.sv
`timescale 1ns/1ps
module tb_link_act_status;
  localparam int HOLD = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ltssm_state = 4'd0;
  logic       tx_tlp_stb = 1'b0, tx_tlp_vdm = 1'b0;
  logic       rx_tlp_stb = 1'b0, rx_tlp_vdm = 1'b0;
  logic       ms_tick = 1'b0;
  logic       link_up_n, active_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  link_act_status dut (
    .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state),
    .tx_tlp_stb(tx_tlp_stb), .tx_tlp_vdm(tx_tlp_vdm),
    .rx_tlp_stb(rx_tlp_stb), .rx_tlp_vdm(rx_tlp_vdm),
    .ms_tick(ms_tick), .link_up_n(link_up_n), .active_n(active_n)
  );

  // {state code, expected link_up_n}  R1 / R2
  localparam logic [4:0] LINK_VEC [0:15] = '{
    {4'd0, 1'b1}, {4'd1, 1'b1}, {4'd2, 1'b1}, {4'd3, 1'b0},
    {4'd4, 1'b0}, {4'd5, 1'b0}, {4'd6, 1'b0}, {4'd7, 1'b1},
    {4'd8, 1'b1}, {4'd9, 1'b1}, {4'd10, 1'b1}, {4'd11, 1'b1},
    {4'd12, 1'b1}, {4'd13, 1'b1}, {4'd14, 1'b1}, {4'd15, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle with the given strobes; inputs cleared afterwards
  task automatic step(input logic ts, input logic tv, input logic rs,
                      input logic rv, input logic tk);
    tx_tlp_stb = ts; tx_tlp_vdm = tv; rx_tlp_stb = rs; rx_tlp_vdm = rv; ms_tick = tk;
    @(negedge clk);
    tx_tlp_stb = 0; tx_tlp_vdm = 0; rx_tlp_stb = 0; rx_tlp_vdm = 0; ms_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9 reset link", link_up_n, 1'b1);
    check("R9 reset act", active_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      ltssm_state = LINK_VEC[i][4:1];
      @(negedge clk);
      check(LINK_VEC[i][0] ? "R2 link down" : "R1 link up", link_up_n, LINK_VEC[i][0]);
    end

    ticks(3);
    check("R8 idle ticks", active_n, 1'b1);
    step(1, 1, 0, 0, 0);
    check("R4 tx vdm ignored", active_n, 1'b1);
    step(0, 0, 1, 1, 0);
    check("R4 rx vdm ignored", active_n, 1'b1);
    step(1, 1, 1, 1, 0);
    check("R4 both vdm ignored", active_n, 1'b1);

    step(1, 0, 0, 0, 0);
    check("R3 tx sets", active_n, 1'b0);
    repeat (5) @(negedge clk);
    check("R8 no tick holds", active_n, 1'b0);
    ticks(HOLD - 1);
    check("R6 before expiry", active_n, 1'b0);
    ticks(1);
    check("R6 at expiry", active_n, 1'b1);

    step(0, 0, 1, 0, 0);
    check("R3 rx sets", active_n, 1'b0);
    ticks(150);
    step(1, 0, 0, 0, 0);
    ticks(HOLD - 1);
    check("R7 restart mid-hold", active_n, 1'b0);
    ticks(1);
    check("R7 restart expiry", active_n, 1'b1);

    step(1, 0, 0, 0, 0);
    ticks(100);
    step(1, 1, 0, 0, 0);
    ticks(HOLD - 101);
    check("R4 vdm no reload", active_n, 1'b0);
    ticks(1);
    check("R4 vdm no reload expiry", active_n, 1'b1);

    step(1, 1, 1, 0, 0);
    check("R5 rx qual with tx vdm", active_n, 1'b0);
    ticks(50);
    step(1, 0, 1, 1, 1);
    ticks(HOLD - 1);
    check("R7 reload beats tick", active_n, 1'b0);
    ticks(1);
    check("R10 hold is 200", active_n, 1'b1);

    step(1, 0, 1, 0, 0);
    check("R5 both qual", active_n, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R9 reset cancels hold", active_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 stays idle after reset", active_n, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule